// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Edge-Selectable Interrupts

This block provides sixteen general-purpose I/O lines behind a small register bus that only honours halfword (16-bit) accesses. Each line is configured as input or output through a direction register. An output latch supplies the level driven onto lines configured as outputs. Input lines pass through a two-flop synchroniser and feed a per-line edge detector. The edge polarity of each line is chosen by its own bit: rising or falling.

A detected edge on an input line whose mask bit is clear sets a sticky status bit. The single interrupt output is high whenever any status bit is set. Software clears status bits by writing ones to them. Reading the input-data register returns the synchronised pin values filtered through a pin-enable register.

Top module: `gpio16_port`

## Requirements
- R1: After reset the output latch, direction, edge-select, mask and pin-enable registers all read 0xFFFF, the status register reads 0x0000, `irq` is 0, `pin_oe` is 0x0000 and `pin_out` is 0x0000.
- R2: Register offsets are 0x00 input data (read-only), 0x04 output latch, 0x08 direction, 0x0C edge select, 0x10 mask, 0x14 status, 0x18 pin enable. A direction bit of 0 makes its line an output, so `pin_oe` is the bitwise inverse of the direction register. `pin_out` carries the latch bit on output lines and 0 on input lines, one clock edge after the write.
- R3: A write to the output latch changes `pin_out` only on lines that are outputs. Turning a line into an output drives the value its latch already holds.
- R4: With edge-select bit 1, a 0-to-1 transition on an input pin sets that line's status bit. `irq` rises on the third rising clock edge after the pin changes: two synchroniser edges, then one status edge.
- R5: With edge-select bit 0, a 1-to-0 transition on an input pin sets that line's status bit.
- R6: A transition of the polarity not selected by the edge-select bit leaves the status register unchanged.
- R7: No status bit is set for a line whose mask bit is 1 or whose direction bit is 0.
- R8: A halfword write to the status register clears every bit written as 1 and keeps the others. `irq` equals 1 exactly while at least one status bit is set.
- R9: A read of the input-data register returns the synchronised pin values ANDed with the pin-enable register. Writes to offset 0x00 change no register.
- R10: Accesses with a size code other than halfword are ignored: a write changes no register, and a read returns the fixed value 0x0000. Size codes are 00 byte, 01 halfword, 10 word.
- R11: A read of an unmapped offset returns 0x0000, and a write to one changes no register.
- R12: When an edge event and a status clear for the same line fall in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access size code: 00 byte, 01 halfword, 10 word |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the cycle of a read access |
| pin_in | input | 16 | Asynchronous pin input levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
Read data is combinational, so each read is compared in the same cycle as the request, before the next rising edge. Register writes take effect at the next edge, so `pin_out` and `pin_oe` are compared one cycle after the write task issues. A pin change reaches the status register and `irq` on the third edge. The bench checks `irq` at that cycle, and checks that it is still low one cycle earlier. The simultaneous set-and-clear case is timed so that the clear write lands in exactly the cycle the edge event registers. Each expectation is queued with its due cycle, and the monitor compares it only when the cycle counter reaches that value.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

    // Register byte offsets
    localparam int unsigned OFF_PIN_IN   = 'h00;
    localparam int unsigned OFF_LATCH    = 'h04;
    localparam int unsigned OFF_DIR      = 'h08;
    localparam int unsigned OFF_EDGE_SEL = 'h0C;
    localparam int unsigned OFF_MASK     = 'h10;
    localparam int unsigned OFF_STATUS   = 'h14;
    localparam int unsigned OFF_PIN_EN   = 'h18;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
    parameter int LINES  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);

    logic [STAGES-1:0][LINES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio16_edge.sv
module gpio16_edge #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    logic [LINES-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
        rise   = level & ~prev_q;
        fall   = ~level & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/gpio16_irq.sv
module gpio16_irq #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] rise,
    input  logic [LINES-1:0] fall,
    input  logic [LINES-1:0] edge_sel,
    input  logic [LINES-1:0] armed,
    input  logic             clr_en,
    input  logic [LINES-1:0] clr_bits,
    output logic [LINES-1:0] status,
    output logic             irq
);

    typedef struct packed {
        logic [LINES-1:0] status;
        logic             irq;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic [LINES-1:0] hit;
    logic [LINES-1:0] clr_vec;

    always_comb begin
        hit       = armed & ((edge_sel & rise) | (~edge_sel & fall));
        clr_vec   = clr_en ? clr_bits : '0;
        // a new event wins over a clear in the same cycle
        s_d.status = (s_q.status & ~clr_vec) | hit;
        s_d.irq    = |s_d.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.status;
    assign irq    = s_q.irq;

endmodule

// File: rtl/gpio16_port.sv
module gpio16_port #(
    parameter int               LINES        = 16,
    parameter int               ADDR_W       = 8,
    parameter int               SYNC_STAGES  = 2,
    parameter logic [LINES-1:0] BAD_RD_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINES-1:0]  req_wdata,
    output logic [LINES-1:0]  rd_data,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq
);
    import gpio16_pkg::*;

    typedef struct packed {
        logic [LINES-1:0] latch;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] edge_sel;
        logic [LINES-1:0] mask;
        logic [LINES-1:0] pin_en;
        logic [LINES-1:0] drive;
    } regs_t;

    localparam regs_t REGS_RST = '{
        latch:    '1,
        dir:      '1,
        edge_sel: '1,
        mask:     '1,
        pin_en:   '1,
        drive:    '0
    };

    regs_t r_d, r_q;

    logic             acc_half;
    logic             wr_ok;
    logic             rd_ok;
    logic             clr_en;
    logic [LINES-1:0] pin_sync;
    logic [LINES-1:0] rise, fall;
    logic [LINES-1:0] status_q;

    assign acc_half = (req_size == ACC_HALF);
    assign wr_ok    = req_valid & req_write & acc_half;
    assign rd_ok    = req_valid & ~req_write;
    assign clr_en   = wr_ok & (req_addr == ADDR_W'(OFF_STATUS));

    gpio16_sync #(
        .LINES  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio16_edge #(
        .LINES (LINES)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pin_sync),
        .rise  (rise),
        .fall  (fall)
    );

    gpio16_irq #(
        .LINES (LINES)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .edge_sel (r_q.edge_sel),
        .armed    (r_q.dir & ~r_q.mask),
        .clr_en   (clr_en),
        .clr_bits (req_wdata),
        .status   (status_q),
        .irq      (irq)
    );

    // next-state of configuration registers
    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            case (req_addr)
                ADDR_W'(OFF_LATCH):    r_d.latch    = req_wdata;
                ADDR_W'(OFF_DIR):      r_d.dir      = req_wdata;
                ADDR_W'(OFF_EDGE_SEL): r_d.edge_sel = req_wdata;
                ADDR_W'(OFF_MASK):     r_d.mask     = req_wdata;
                ADDR_W'(OFF_PIN_EN):   r_d.pin_en   = req_wdata;
                default: ;
            endcase
        end
        // driven value changes only where the line is an output
        r_d.drive = r_d.latch & ~r_d.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    // read path
    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            if (!acc_half) begin
                rd_data = BAD_RD_VALUE;
            end else begin
                case (req_addr)
                    ADDR_W'(OFF_PIN_IN):   rd_data = pin_sync & r_q.pin_en;
                    ADDR_W'(OFF_LATCH):    rd_data = r_q.latch;
                    ADDR_W'(OFF_DIR):      rd_data = r_q.dir;
                    ADDR_W'(OFF_EDGE_SEL): rd_data = r_q.edge_sel;
                    ADDR_W'(OFF_MASK):     rd_data = r_q.mask;
                    ADDR_W'(OFF_STATUS):   rd_data = status_q;
                    ADDR_W'(OFF_PIN_EN):   rd_data = r_q.pin_en;
                    default:               rd_data = '0;
                endcase
            end
        end
    end

    assign pin_out = r_q.drive;
    assign pin_oe  = ~r_q.dir;

endmodule

// File: rtl/gpio16_port_chk.sv
module gpio16_port_chk #(
    parameter int LINES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_size,
    input logic [LINES-1:0] pin_out,
    input logic [LINES-1:0] pin_oe,
    input logic             irq,
    input logic [LINES-1:0] latch_q,
    input logic [LINES-1:0] dir_q,
    input logic [LINES-1:0] edge_q,
    input logic [LINES-1:0] mask_q,
    input logic [LINES-1:0] pen_q,
    input logic [LINES-1:0] status_q
);

    // R2: nothing is driven high on a line that is not enabled as output
    assert_drive_only_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R8: the interrupt follows the status register
    assert_irq_tracks_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status_q != '0));

    // R10: non-halfword writes leave every register unchanged
    assert_badwidth_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != 2'b01) |=>
            ($stable(latch_q) && $stable(dir_q) && $stable(edge_q) &&
             $stable(mask_q) && $stable(pen_q)));

    // R7: newly set status bits belong to unmasked input lines
    assert_blocked_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q)) &
                  ($past(mask_q) | ~$past(dir_q))) == '0);

endmodule

bind gpio16_port gpio16_port_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .latch_q   (r_q.latch),
    .dir_q     (r_q.dir),
    .edge_q    (r_q.edge_sel),
    .mask_q    (r_q.mask),
    .pen_q     (r_q.pin_en),
    .status_q  (status_q)
);

// File: tb/tb_gpio16_port.sv
module tb_gpio16_port;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_IN   = 8'h00;
    localparam logic [7:0] A_LAT  = 8'h04;
    localparam logic [7:0] A_DIR  = 8'h08;
    localparam logic [7:0] A_EDGE = 8'h0C;
    localparam logic [7:0] A_MASK = 8'h10;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam logic [7:0] A_PEN  = 8'h18;

    localparam logic [1:0] SZ_B = 2'b00;
    localparam logic [1:0] SZ_H = 2'b01;
    localparam logic [1:0] SZ_W = 2'b10;

    localparam int S_RD  = 0;
    localparam int S_OUT = 1;
    localparam int S_OE  = 2;
    localparam int S_IRQ = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = SZ_H;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    gpio16_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] pick(int sel);
        case (sel)
            S_RD:    return rd_data;
            S_OUT:   return pin_out;
            S_OE:    return pin_oe;
            default: return {15'b0, irq};
        endcase
    endfunction

    // monitor: compare due items away from the clock edge
    always @(negedge clk) begin
        #2;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [15:0] act;
                act = pick(sb[i].sel);
                total++;
                if (act !== sb[i].exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h (cycle %0d)",
                             sb[i].tag, act, sb[i].exp, cyc);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(int delay, int sel, logic [15:0] exp, string tag);
        item_t it;
        it.due = cyc + delay;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drv(bit v, bit w, logic [1:0] sz, logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        req_valid = v;
        req_write = w;
        req_size  = sz;
        req_addr  = a;
        req_wdata = d;
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        drv(1'b1, 1'b1, SZ_H, a, d);
    endtask

    task automatic rd_chk(logic [7:0] a, logic [1:0] sz, logic [15:0] exp, string tag);
        drv(1'b1, 1'b0, sz, a, '0);
        push(0, S_RD, exp, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drv(1'b0, 1'b0, SZ_H, '0, '0);
    endtask

    task automatic pin(logic [15:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        pin_in    = v;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_LAT,  SZ_H, 16'hFFFF, "R1 latch reset");
        rd_chk(A_DIR,  SZ_H, 16'hFFFF, "R1 dir reset");
        rd_chk(A_EDGE, SZ_H, 16'hFFFF, "R1 edge reset");
        rd_chk(A_MASK, SZ_H, 16'hFFFF, "R1 mask reset");
        rd_chk(A_PEN,  SZ_H, 16'hFFFF, "R1 pin-enable reset");
        rd_chk(A_STAT, SZ_H, 16'h0000, "R1 status reset");
        push(0, S_IRQ, 16'h0000, "R1 irq reset");
        push(0, S_OE,  16'h0000, "R1 oe reset");
        push(0, S_OUT, 16'h0000, "R1 pin_out reset");

        // R2 direction and drive
        wr(A_DIR, 16'hFF00);
        push(1, S_OE,  16'h00FF, "R2 oe after dir");
        push(1, S_OUT, 16'h00FF, "R2 drive after dir");
        // R3 latch writes reach only output lines
        wr(A_LAT, 16'h5A0F);
        push(1, S_OUT, 16'h000F, "R3 latch on outputs only");
        wr(A_DIR, 16'h0F00);
        push(1, S_OE,  16'hF0FF, "R3 oe widened");
        push(1, S_OUT, 16'h500F, "R3 new outputs drive latch");
        wr(A_DIR, 16'hFF00);
        push(1, S_OUT, 16'h000F, "R3 back to inputs");
        rd_chk(A_DIR, SZ_H, 16'hFF00, "R2 dir readback");

        // R9 input read gated by pin enable
        pin(16'h3C00);
        idle(3);
        rd_chk(A_IN, SZ_H, 16'h3C00, "R9 input read");
        wr(A_PEN, 16'h0F00);
        rd_chk(A_IN, SZ_H, 16'h0C00, "R9 pin-enable gating");
        wr(A_IN, 16'hFFFF);
        rd_chk(A_IN, SZ_H, 16'h0C00, "R9 input write ignored");
        rd_chk(A_LAT, SZ_H, 16'h5A0F, "R9 input write hits nothing");
        wr(A_PEN, 16'hFFFF);
        rd_chk(A_STAT, SZ_H, 16'h0000, "R7 masked edges not recorded");

        // R4 rising edge with edge bit 1
        wr(A_MASK, 16'h0000);
        pin(16'h3D00);
        push(2, S_IRQ, 16'h0000, "R4 irq not yet");
        push(3, S_IRQ, 16'h0001, "R4 irq on third edge");
        idle(3);
        rd_chk(A_STAT, SZ_H, 16'h0100, "R4 rising status");

        // R6 opposite polarity ignored
        pin(16'h3900);
        idle(3);
        rd_chk(A_STAT, SZ_H, 16'h0100, "R6 falling on rising line");

        // R5 falling edge with edge bit 0
        wr(A_EDGE, 16'hF7FF);
        pin(16'h3100);
        idle(3);
        rd_chk(A_STAT, SZ_H, 16'h0900, "R5 falling status");

        // R7 masked line and output line blocked
        wr(A_MASK, 16'h1000);
        pin(16'h2100);
        idle(3);
        pin(16'h3100);
        idle(3);
        pin(16'h3101);
        idle(3);
        rd_chk(A_STAT, SZ_H, 16'h0900, "R7 masked and output lines");

        // R8 write-one-to-clear
        wr(A_STAT, 16'h0100);
        push(1, S_IRQ, 16'h0001, "R8 irq held by remaining bit");
        rd_chk(A_STAT, SZ_H, 16'h0800, "R8 partial clear");
        wr(A_STAT, 16'h0800);
        push(1, S_IRQ, 16'h0000, "R8 irq drops");
        rd_chk(A_STAT, SZ_H, 16'h0000, "R8 all cleared");

        // R12 event and clear in the same cycle
        pin(16'h3001);
        idle(3);
        pin(16'h3101);
        idle(1);
        wr(A_STAT, 16'h0100);
        push(1, S_IRQ, 16'h0001, "R12 set wins irq");
        rd_chk(A_STAT, SZ_H, 16'h0100, "R12 set wins status");
        wr(A_STAT, 16'hFFFF);
        push(1, S_IRQ, 16'h0000, "R8 full clear");

        // R10 non-halfword accesses
        drv(1'b1, 1'b1, SZ_B, A_MASK, 16'hFFFF);
        drv(1'b1, 1'b1, SZ_W, A_DIR, 16'h0000);
        push(1, S_OE, 16'h00FF, "R10 word write ignored");
        rd_chk(A_MASK, SZ_H, 16'h1000, "R10 byte write ignored");
        rd_chk(A_MASK, SZ_B, 16'h0000, "R10 byte read fixed");
        rd_chk(A_DIR,  SZ_W, 16'h0000, "R10 word read fixed");
        rd_chk(A_DIR,  SZ_H, 16'hFF00, "R10 dir intact");

        // R11 unmapped offsets
        rd_chk(8'h1C, SZ_H, 16'h0000, "R11 unmapped read");
        wr(8'h1C, 16'h1234);
        rd_chk(8'h02, SZ_H, 16'h0000, "R11 misaligned read");
        rd_chk(A_LAT,  SZ_H, 16'h5A0F, "R11 latch intact");
        rd_chk(A_EDGE, SZ_H, 16'hF7FF, "R11 edge intact");

        idle(5);
        if (sb.size() != 0) begin
            bad += sb.size();
            total += sb.size();
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule